// File: doc/BRIEF.md
# Transmit Descriptor List DMA Engine

This block moves outgoing frame data from a word-addressed memory onto a byte stream. Software builds a list of four-word descriptors. Each descriptor names a buffer, gives its length and sets a few control flags. Software then hands each descriptor to the engine by setting its ownership bit. The engine walks the list and reads every buffer it owns. It sends the buffer bytes downstream with markers for the first and last byte of a frame. It then writes the descriptor's control word back with ownership cleared and the error outcome recorded. On request it raises an interrupt when that is done.

A frame can be split over several descriptors, from the one marked first-segment to the one marked last-segment. The next descriptor is found in one of three ways: the list base after an end-of-ring descriptor, a link word when chaining is selected, or the next four words otherwise. When the engine finds a descriptor it does not own, it suspends. A poll strobe makes it read that same descriptor again. Dropping the run input stops the engine, but only once the frame in progress has been sent in full.

Top module: `txdma_engine`

## Requirements
- R1: While reset is asserted, and after reset while `run` is low, the engine makes no memory access, `tx_valid` is 0 and `irq` is 0.
- R2: When `run` goes high, the engine reads the four words at `list_base`. The descriptor is hardware-owned when bit 31 of word 0 is 1. A descriptor that is not owned puts the engine into suspension, where it makes no memory access. Each `poll` strobe in suspension re-reads the same four words exactly once.
- R3: Bits 11:0 of word 1 give the byte count. Word 2 gives the word address of the buffer. Byte i of the buffer is taken from address word2 + i/4, bits 8*(i%4)+7 down to 8*(i%4), and bytes are sent in increasing i.
- R4: `tx_first` marks byte 0 of a descriptor whose bit 28 (first segment) is set. `tx_last` marks the final byte of a descriptor whose bit 29 (last segment) is set. A frame spread over several descriptors therefore carries exactly one first mark and one last mark.
- R5: After its last byte, the descriptor's word 0 is written back unchanged except for two bits. Bit 31 is cleared. Bit 15 is 1 exactly when `tx_err` was high during a data cycle of that descriptor.
- R6: After write-back, the next descriptor is taken from `list_base` if bit 21 (end of ring) is set. Otherwise it is taken from word 3 if bit 20 (chained) is set. Otherwise it is the current address plus 4.
- R7: When bit 30 of word 0 is set, `irq` goes high after the write-back and stays high until `irq_clr` is pulsed.
- R8: When `run` goes low, it takes effect only after the write-back of a descriptor with bit 29 set, or at once if no frame is open while suspended. Once stopped, the engine ignores `poll`. Raising `run` again restarts it from `list_base`.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_data`, `tx_first` and `tx_last` hold their values.
- R10: A descriptor with a byte count of 0 sends no bytes and is still written back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Start (high) / stop (low) request |
| poll | input | 1 | Poll-demand strobe, one cycle |
| list_base | input | AW | Word address of the first descriptor |
| irq_clr | input | 1 | Write-one-to-clear of the completion status |
| irq | output | 1 | Transmit-complete status / interrupt |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (with mem_en) |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| tx_data | output | 8 | Stream byte |
| tx_valid | output | 1 | Stream byte valid |
| tx_first | output | 1 | First byte of a frame |
| tx_last | output | 1 | Last byte of a frame |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_err | input | 1 | Downstream reports a transmit failure |

## Verification
After a poll strobe or a rise of `run`, four read cycles, one wait cycle, one evaluation cycle and one buffer-read round trip pass before the first byte appears. Each later group of four bytes costs two more cycles for the buffer read. The write-back follows in the cycle after the final byte is accepted, and `irq` rises one edge after that. Because backpressure makes these counts vary, the bench does not sample at fixed offsets. It waits for the observable result: the ownership bit clearing in its memory model, followed by a settle margin. It samples stream and memory signals one time unit after the falling edge, once every register on the path has updated.

// File: rtl/txd_pkg.sv
package txd_pkg;
  // Control word bit positions (the descriptor layout is shared with software)
  localparam int unsigned BIT_OWN   = 31;
  localparam int unsigned BIT_IOC   = 30;
  localparam int unsigned BIT_LSEG  = 29;
  localparam int unsigned BIT_FSEG  = 28;
  localparam int unsigned BIT_EOR   = 21;
  localparam int unsigned BIT_CHAIN = 20;
  localparam int unsigned BIT_ERR   = 15;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned DESC_WORDS = 4;

  typedef enum logic [3:0] {
    ST_STOP  = 4'd0,
    ST_FETCH = 4'd1,
    ST_FWAIT = 4'd2,
    ST_EVAL  = 4'd3,
    ST_LOAD  = 4'd4,
    ST_LWAIT = 4'd5,
    ST_SEND  = 4'd6,
    ST_WB    = 4'd7,
    ST_SUSP  = 4'd8
  } eng_state_e;
endpackage

// File: rtl/txd_lane_sel.sv
module txd_lane_sel #(
  parameter int unsigned LANES = 4,
  localparam int unsigned SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [8*LANES-1:0] word_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic [7:0]         byte_o
);
  logic [7:0] lane [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = word_i[8*g +: 8];
  end

  assign byte_o = lane[sel_i];
endmodule

// File: rtl/txd_next_addr.sv
module txd_next_addr #(
  parameter int unsigned AW = 16
) (
  input  logic [AW-1:0] cur_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] link_i,
  input  logic          eor_i,
  input  logic          chain_i,
  output logic [AW-1:0] next_o
);
  localparam logic [AW-1:0] STRIDE = AW'(txd_pkg::DESC_WORDS);

  always_comb begin
    if (eor_i)        next_o = base_i;
    else if (chain_i) next_o = link_i;
    else              next_o = cur_i + STRIDE;
  end
endmodule

// File: rtl/txd_irq_stat.sv
module txd_irq_stat (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);
  logic irq_q, irq_d;

  always_comb begin
    irq_d = irq_q;
    if (clr_i) irq_d = 1'b0;
    if (set_i) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  assert_irq_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> irq_o);
  assert_irq_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !irq_o);
endmodule

// File: rtl/txdma_engine.sv
module txdma_engine #(
  parameter int unsigned AW    = 16,
  parameter int unsigned LEN_W = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          poll,
  input  logic [AW-1:0] list_base,
  input  logic          irq_clr,
  output logic          irq,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic [7:0]    tx_data,
  output logic          tx_valid,
  output logic          tx_first,
  output logic          tx_last,
  input  logic          tx_ready,
  input  logic          tx_err
);
  import txd_pkg::*;

  localparam int unsigned LANES = WORD_W / 8;
  localparam int unsigned LSB_W = $clog2(LANES);
  localparam logic [LEN_W-1:0] ONE_LEN = LEN_W'(1);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  eng_state_e       st_q, st_d;
  logic [AW-1:0]    cur_q, cur_d;
  logic [1:0]       fidx_q, fidx_d;
  logic [1:0]       ftag_q;
  logic             fpend_q, fpend_d;
  logic             lpend_q, lpend_d;
  logic [LEN_W-1:0] bcnt_q, bcnt_d;
  logic             err_q, err_d;
  logic             frm_q, frm_d;
  logic [31:0]      ctl_q;
  logic [LEN_W-1:0] len_q;
  logic [AW-1:0]    badr_q;
  logic [AW-1:0]    link_q;
  logic [31:0]      wbuf_q;
  logic [AW-1:0]    next_addr;
  logic [31:0]      wb_word;
  logic             irq_set;
  logic             in_data;
  logic             final_byte;

  txd_next_addr #(.AW(AW)) u_next (
    .cur_i  (cur_q),
    .base_i (list_base),
    .link_i (link_q),
    .eor_i  (ctl_q[BIT_EOR]),
    .chain_i(ctl_q[BIT_CHAIN]),
    .next_o (next_addr)
  );

  txd_lane_sel #(.LANES(LANES)) u_lane (
    .word_i(wbuf_q),
    .sel_i (bcnt_q[LSB_W-1:0]),
    .byte_o(tx_data)
  );

  txd_irq_stat u_irq (
    .clk  (clk),
    .rst_n(rst_ni),
    .set_i(irq_set),
    .clr_i(irq_clr),
    .irq_o(irq)
  );

  assign wb_word    = (ctl_q & ~((32'h1 << BIT_OWN) | (32'h1 << BIT_ERR)))
                    | ({31'b0, err_q} << BIT_ERR);
  assign in_data    = (st_q == ST_LOAD) || (st_q == ST_LWAIT) || (st_q == ST_SEND);
  assign final_byte = (bcnt_q == len_q - ONE_LEN);
  assign tx_first   = tx_valid && ctl_q[BIT_FSEG] && (bcnt_q == '0);
  assign tx_last    = tx_valid && ctl_q[BIT_LSEG] && final_byte;

  // Next-state process
  always_comb begin
    st_d      = st_q;
    cur_d     = cur_q;
    fidx_d    = fidx_q;
    bcnt_d    = bcnt_q;
    err_d     = err_q;
    frm_d     = frm_q;
    fpend_d   = 1'b0;
    lpend_d   = 1'b0;
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_q;
    mem_wdata = wb_word;
    tx_valid  = 1'b0;
    irq_set   = 1'b0;
    unique case (st_q)
      ST_STOP: begin
        if (run) begin
          cur_d  = list_base;
          frm_d  = 1'b0;
          fidx_d = 2'd0;
          st_d   = ST_FETCH;
        end
      end
      ST_FETCH: begin
        mem_en   = 1'b1;
        mem_addr = cur_q + AW'(fidx_q);
        fpend_d  = 1'b1;
        fidx_d   = fidx_q + 2'd1;
        if (fidx_q == 2'd3) st_d = ST_FWAIT;
      end
      ST_FWAIT: st_d = ST_EVAL;
      ST_EVAL: begin
        if (!ctl_q[BIT_OWN]) begin
          st_d = ST_SUSP;
        end else begin
          bcnt_d = '0;
          err_d  = 1'b0;
          st_d   = (len_q == '0) ? ST_WB : ST_LOAD;
        end
      end
      ST_LOAD: begin
        mem_en   = 1'b1;
        mem_addr = badr_q + AW'(bcnt_q >> LSB_W);
        lpend_d  = 1'b1;
        st_d     = ST_LWAIT;
      end
      ST_LWAIT: st_d = ST_SEND;
      ST_SEND: begin
        tx_valid = 1'b1;
        if (tx_ready) begin
          bcnt_d = bcnt_q + ONE_LEN;
          if (final_byte)                        st_d = ST_WB;
          else if (bcnt_q[LSB_W-1:0] == '1)      st_d = ST_LOAD;
        end
      end
      ST_WB: begin
        mem_en  = 1'b1;
        mem_we  = 1'b1;
        cur_d   = next_addr;
        frm_d   = !ctl_q[BIT_LSEG];
        irq_set = ctl_q[BIT_IOC];
        fidx_d  = 2'd0;
        st_d    = (!run && ctl_q[BIT_LSEG]) ? ST_STOP : ST_FETCH;
      end
      ST_SUSP: begin
        if (!run && !frm_q) begin
          st_d = ST_STOP;
        end else if (poll) begin
          fidx_d = 2'd0;
          st_d   = ST_FETCH;
        end
      end
      default: st_d = ST_STOP;
    endcase
    if (in_data && tx_err) err_d = 1'b1;
  end

  // Register process
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_STOP;
      cur_q   <= '0;
      fidx_q  <= '0;
      ftag_q  <= '0;
      fpend_q <= 1'b0;
      lpend_q <= 1'b0;
      bcnt_q  <= '0;
      err_q   <= 1'b0;
      frm_q   <= 1'b0;
      ctl_q   <= '0;
      len_q   <= '0;
      badr_q  <= '0;
      link_q  <= '0;
      wbuf_q  <= '0;
    end else begin
      st_q    <= st_d;
      cur_q   <= cur_d;
      fidx_q  <= fidx_d;
      ftag_q  <= fidx_q;
      fpend_q <= fpend_d;
      lpend_q <= lpend_d;
      bcnt_q  <= bcnt_d;
      err_q   <= err_d;
      frm_q   <= frm_d;
      if (fpend_q && ftag_q == 2'd0) ctl_q  <= mem_rdata;
      if (fpend_q && ftag_q == 2'd1) len_q  <= mem_rdata[LEN_W-1:0];
      if (fpend_q && ftag_q == 2'd2) badr_q <= mem_rdata[AW-1:0];
      if (fpend_q && ftag_q == 2'd3) link_q <= mem_rdata[AW-1:0];
      if (lpend_q)                   wbuf_q <= mem_rdata;
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)
                                 && $stable(tx_first) && $stable(tx_last)));
  assert_last_gap_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (tx_valid && tx_ready && tx_last) |=> !tx_valid);
  assert_irq_after_wb_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(irq) |-> $past(mem_we));
  assert_wb_own_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_we |-> (mem_en && !mem_wdata[BIT_OWN]));
  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_STOP && !run) |=> !mem_en);
endmodule

// File: tb/sim_txdma_engine.sv
module sim_txdma_engine;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 16;
  localparam logic [31:0] OWN = 32'h8000_0000, IOC = 32'h4000_0000,
    LS = 32'h2000_0000, FS = 32'h1000_0000, EOR = 32'h0020_0000,
    CHN = 32'h0010_0000, ES = 32'h0000_8000;
  // {len[11:0], ioc, err, ready_mode[1:0]}
  localparam logic [15:0] VEC [6] = '{
    {12'd5,  1'b0, 1'b0, 2'd0},
    {12'd8,  1'b1, 1'b0, 2'd1},
    {12'd1,  1'b0, 1'b1, 2'd2},
    {12'd13, 1'b0, 1'b0, 2'd1},
    {12'd4,  1'b1, 1'b1, 2'd0},
    {12'd7,  1'b0, 1'b0, 2'd2}
  };

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, poll = 1'b0, irq_clr = 1'b0;
  logic [15:0] list_base = 16'(BASE);
  logic irq, mem_en, mem_we, tx_valid, tx_first, tx_last;
  logic tx_ready = 1'b1, tx_err = 1'b0;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [7:0] tx_data;

  logic [31:0] mem [256];
  logic bw_en = 1'b0, bw_clr = 1'b0;
  logic [7:0] bw_a = '0;
  logic [31:0] bw_d = '0;

  int checks = 0, fails = 0, cyc = 0, mem_acc = 0, cap_n = 0;
  int rdy_mode = 0;
  bit err_on = 1'b0, done = 1'b0;
  logic [7:0] cap_d [64];
  bit cap_f [64], cap_l [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  txdma_engine u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .poll(poll), .list_base(list_base),
    .irq_clr(irq_clr), .irq(irq), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_first(tx_first),
    .tx_last(tx_last), .tx_ready(tx_ready), .tx_err(tx_err));

  // Memory model: one-cycle read latency, bench write port beside the engine
  always @(posedge clk) begin
    if (bw_clr) for (int i = 0; i < 256; i++) mem[i] <= '0;
    else if (bw_en) mem[bw_a] <= bw_d;
    if (mem_en) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[7:0]];
    end
  end

  function automatic logic [7:0] pat(int k, int i);
    return 8'((k * 37) + (i * 11) + 5);
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Sink / monitor: drives ready and error, records accepted bytes
  initial begin
    logic [7:0] hd;
    bit hf, hl, stall;
    stall = 1'b0; hd = '0; hf = 1'b0; hl = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      tx_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? cyc[0] : (cyc % 3 == 0);
      #1;
      tx_err = err_on && tx_valid;
      if (mem_en) mem_acc++;
      if (stall && tx_valid)
        check(tx_data == hd && tx_first == hf && tx_last == hl, "R9",
              {tx_first, tx_last, tx_data}, {hf, hl, hd});
      stall = tx_valid && !tx_ready;
      hd = tx_data; hf = tx_first; hl = tx_last;
      if (tx_valid && tx_ready && cap_n < 64) begin
        cap_d[cap_n] = tx_data; cap_f[cap_n] = tx_first; cap_l[cap_n] = tx_last;
        cap_n++;
      end
    end
  end

  task automatic wr(int a, logic [31:0] d);
    bw_en = 1'b1; bw_a = 8'(a); bw_d = d;
    @(negedge clk);
    bw_en = 1'b0;
  endtask

  task automatic fill(int a, int k, int len);
    for (int j = 0; j < (len + 3) / 4; j++)
      wr(a + j, {pat(k, 4*j+3), pat(k, 4*j+2), pat(k, 4*j+1), pat(k, 4*j)});
  endtask

  task automatic desc(int a, logic [31:0] w0, int len, int buf_a, int link);
    wr(a + 1, 32'(len)); wr(a + 2, 32'(buf_a)); wr(a + 3, 32'(link)); wr(a, w0);
  endtask

  task automatic pulse_poll();
    poll = 1'b1; @(negedge clk); poll = 1'b0;
  endtask

  task automatic wait_free(int a);
    while (mem[a][31]) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int bad, k;
    logic [31:0] w0;
    // R1: reset state
    bw_clr = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(!tx_valid && !mem_en && !irq, "R1", {tx_valid, mem_en, irq}, 0);
    @(negedge clk);
    bw_clr = 1'b0;
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(mem_acc == 0 && !irq, "R1", mem_acc, 0);

    // Table walk: single-descriptor frames, ring of one (R3 R4 R5 R6 R7)
    for (int v = 0; v < 6; v++) begin
      int len;
      bit ioc, er;
      len = int'(VEC[v][15:4]); ioc = VEC[v][3]; er = VEC[v][2];
      rdy_mode = int'(VEC[v][1:0]); err_on = er; cap_n = 0;
      fill(64, v, len);
      w0 = OWN | FS | LS | EOR | (ioc ? IOC : 32'h0) | 32'(v + 1);
      desc(BASE, w0, len, 64, 0);
      if (v == 0) run = 1'b1; else pulse_poll();
      wait_free(BASE);
      err_on = 1'b0;
      bad = 0;
      for (int i = 0; i < len; i++) if (cap_d[i] != pat(v, i)) bad++;
      check(cap_n == len && bad == 0, "R3", cap_n * 1000 + bad, len * 1000);
      check(cap_f[0] && cap_l[len-1] && (len == 1 || (!cap_f[len-1] && !cap_l[0])),
            "R4", {cap_f[0], cap_l[len-1]}, 2'b11);
      check(mem[BASE] == ((w0 & ~OWN) | (er ? ES : 32'h0)), "R5",
            mem[BASE], (w0 & ~OWN) | (er ? ES : 32'h0));
      check(irq == ioc, "R7", irq, ioc);
      if (ioc) begin
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0; #1;
        check(!irq, "R7", irq, 0);
      end
    end
    rdy_mode = 0;

    // R2: suspended engine idles, poll re-reads the same four words once
    repeat (10) @(negedge clk);
    k = mem_acc;
    repeat (20) @(negedge clk);
    check(mem_acc == k, "R2", mem_acc - k, 0);
    pulse_poll();
    repeat (20) @(negedge clk);
    check(mem_acc - k == 4, "R2", mem_acc - k, 4);

    // R10: zero-length descriptor
    cap_n = 0;
    desc(BASE, OWN | FS | LS | EOR, 0, 64, 0);
    pulse_poll();
    wait_free(BASE);
    check(cap_n == 0 && mem[BASE] == (FS | LS | EOR), "R10", mem[BASE], FS | LS | EOR);

    // R6 R4: frame over three descriptors (chained, contiguous, end of ring)
    cap_n = 0;
    fill(64, 10, 3); fill(80, 11, 6); fill(96, 12, 2);
    desc(40, OWN, 6, 80, 0);
    desc(44, OWN | LS | EOR, 2, 96, 0);
    desc(BASE, OWN | FS | CHN, 3, 64, 40);
    pulse_poll();
    wait_free(44);
    bad = 0;
    for (int i = 0; i < 11; i++) begin
      logic [7:0] e;
      e = (i < 3) ? pat(10, i) : (i < 9) ? pat(11, i - 3) : pat(12, i - 9);
      if (cap_d[i] != e || cap_f[i] != (i == 0) || cap_l[i] != (i == 10)) bad++;
    end
    check(cap_n == 11 && bad == 0, "R4", cap_n * 1000 + bad, 11000);
    check(mem[BASE] == (FS | CHN) && mem[40] == 0 && mem[44] == (LS | EOR), "R6",
          mem[40], 0);
    repeat (10) @(negedge clk);
    check(!tx_valid && mem_acc > 0, "R6", tx_valid, 0);

    // R8: stop request during a two-descriptor frame
    cap_n = 0; rdy_mode = 2;
    fill(64, 20, 6); fill(80, 21, 3);
    desc(20, OWN | LS | EOR, 3, 80, 0);
    desc(BASE, OWN | FS, 6, 64, 0);
    pulse_poll();
    while (cap_n < 1) @(negedge clk);
    run = 1'b0;
    wait_free(20);
    bad = 0;
    for (int i = 0; i < 9; i++) if (cap_d[i] != (i < 6 ? pat(20, i) : pat(21, i - 6))) bad++;
    check(cap_n == 9 && bad == 0 && mem[BASE][31] == 0, "R8", cap_n * 1000 + bad, 9000);
    rdy_mode = 0;
    k = mem_acc;
    fill(96, 22, 2);
    desc(BASE, OWN | FS | LS | EOR, 2, 96, 0);
    k = mem_acc;
    pulse_poll();
    repeat (30) @(negedge clk);
    check(mem_acc == k && mem[BASE][31] && cap_n == 9, "R8", mem_acc - k, 0);
    run = 1'b1;
    wait_free(BASE);
    check(cap_n == 11 && cap_d[9] == pat(22, 0) && cap_d[10] == pat(22, 1) && cap_l[10],
          "R8", cap_n, 11);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule